// File: doc/BRIEF.md
# Phase-Qualified Packet FIFO Port

This block is the word-wide packet queue that sits between a microcoded network controller and its line-side machinery. It serves both directions. Microcode places a 16-bit word in a holding register, then commits it to the queue with a strobe. On the receive side, microcode reads queued words back one at a time. Every microcode operation carries the 2-bit microcycle phase it was issued in, and the phase decides what the operation does.

A single strobe input has two meanings. In phases c1 and c3 it commits the holding register. In phase c2 it starts a purge, which throws away the remaining words of an incoming packet one per cycle. A read only consumes a word when it is issued in c2. A read in any other phase is a re-read: it leaves the queue alone and the read register keeps the word it already holds.

The transmit serializer drains the queue through a take input. When loopback mode is set, that drain is suppressed, so microcode can read its own transmitted words back through the read port.

Top module: `pkt_fifo_port`

## Requirements
- R1: A write (`wr_en`) in any phase loads `wr_data` into the holding register only. The queue contents and flags do not change.
- R2: The phase encoding is 0 = idle, 1 = c1, 2 = c2, 3 = c3. A strobe in c1 or c3 enqueues the holding register on that clock edge. A strobe in the idle phase has no effect.
- R3: A strobe in c2 sets `purge` on that edge. While `purge` is set, one queued word is discarded each cycle and `data_ready` is low. `purge` clears on the first edge where it is set and either the queue is empty or `rx_enable` is low.
- R4: A read (`rd_en`) in c2 while the queue is not empty and no purge is active removes the head word. That word appears on `rd_data` after the edge.
- R5: A read in any phase other than c2 does not remove a word, and `rd_data` keeps its previous value.
- R6: With `loopback` low, `tx_take` removes the head word, which is shown on `tx_data`. With `loopback` high, `tx_take` is ignored and the words stay readable.
- R7: `space_avail` is high while fewer than DEPTH (default 16) words are queued. `data_ready` is high while at least one word is queued and no purge is active.
- R8: An enqueue into a full queue is ignored. A c2 read or a `tx_take` pop on an empty queue is ignored. Each of these events sets `err`, which stays set until reset.
- R9: Words leave the queue in the order they were enqueued, across pointer wraparound.
- R10: After reset the queue is empty, `space_avail` is 1, and `data_ready`, `purge`, `err` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase | input | 2 | Microcycle phase of the current operation (0 idle, 1 c1, 2 c2, 3 c3) |
| wr_en | input | 1 | Load the holding register |
| wr_data | input | 16 | Word for the holding register |
| strobe | input | 1 | Enqueue (c1/c3) or purge (c2) |
| rd_en | input | 1 | Read input data; pops only in c2 |
| loopback | input | 1 | Suppress the transmit-side drain |
| rx_enable | input | 1 | Reception enabled; low ends a purge |
| tx_take | input | 1 | Line side consumes the head word |
| rd_data | output | 16 | Last word popped by a c2 read |
| tx_data | output | 16 | Head word of the queue |
| space_avail | output | 1 | Queue not full |
| data_ready | output | 1 | Queue not empty and not purging |
| purge | output | 1 | Purge in progress |
| err | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench exercises the phase qualification, as follows:
- Strobes and reads are issued in every phase. A design that enqueued on an idle or c2 strobe, or that popped on a c1/c3 re-read, would show a wrong `data_ready` or a changed `rd_data`.
- A purge is timed cycle by cycle. It is also cut short by dropping `rx_enable`, which catches a purge that flushes everything at once or never ends.
- The queue is filled to its limit and pushed once more, and an empty queue is read. A design that wrapped over old data or lost the sticky error would return out-of-order words or a low `err`.
- Loopback is checked by taking words while it is set and showing that they can still be read back.

// File: rtl/pfp_pkg.sv
// Package: shared phase encoding for the phase-qualified packet FIFO port.
// Assumes the phase input is a 2-bit code valid whenever an operation is issued.
package pfp_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_C1   = 2'd1,
        PH_C2   = 2'd2,
        PH_C3   = 2'd3
    } phase_e;

    localparam int WORD_W = 16;
endpackage

// File: rtl/pfp_phase_decode.sv
// Module: pfp_phase_decode
// Turns the raw strobe and read requests into phase-qualified actions:
// commit (c1/c3 strobe), purge start (c2 strobe) and a consuming read (c2).
// Assumes: purely combinational; the caller registers any state.
module pfp_phase_decode
    import pfp_pkg::*;
(
    input  logic [1:0] phase,
    input  logic       strobe,
    input  logic       rd_en,
    output logic       commit,
    output logic       purge_req,
    output logic       rd_pop_req
);
    phase_e ph;

    // Decode phase-dependent meaning of strobe and read
    always_comb begin
        ph         = phase_e'(phase);
        commit     = strobe && ((ph == PH_C1) || (ph == PH_C3));
        purge_req  = strobe && (ph == PH_C2);
        rd_pop_req = rd_en  && (ph == PH_C2);
    end
endmodule

// File: rtl/pfp_ring.sv
// Module: pfp_ring
// Circular word store with read/write pointers and an occupancy count.
// A push into a full store and a pop from an empty store are dropped.
// Assumes: at most one push and one pop request per cycle; DEPTH >= 2.
module pfp_ring #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    // Gate requests against the occupancy
    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        head    = mem[rd_ptr];
    end

    // Storage write; no reset needed on data
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    // Pointer and count update with wraparound
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R8
    full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == $past(count)));

    // R8
    empty_pop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/pfp_purge_ctl.sv
// Module: pfp_purge_ctl
// Holds the purge flag: set by a c2 strobe, then requests one discard per
// cycle until the store is empty or reception is turned off.
// Assumes: 'empty' reflects the occupancy before this cycle's edge.
module pfp_purge_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic purge_req,
    input  logic empty,
    input  logic rx_enable,
    output logic purge,
    output logic drop
);
    // Discard the head word each cycle a purge is active
    always_comb drop = purge && !empty;

    // Purge flag set/clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            purge <= 1'b0;
        else if (purge_req)
            purge <= 1'b1;
        else if (purge && (empty || !rx_enable))
            purge <= 1'b0;
    end

    // R3
    purge_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (purge && (empty || !rx_enable) && !purge_req) |=> !purge);

    // R3
    purge_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        purge_req |=> purge);
endmodule

// File: rtl/pkt_fifo_port.sv
// Module: pkt_fifo_port (top)
// Phase-qualified packet FIFO port. Writes load a holding register; a c1/c3
// strobe commits it; a c2 strobe purges; a c2 read pops into rd_data; the
// line side drains with tx_take unless loopback is set.
// Assumes: one microcode operation set per cycle; phase is 0 when idle.
module pkt_fifo_port #(
    parameter int DEPTH = 16,
    parameter int WIDTH = pfp_pkg::WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       phase,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             strobe,
    input  logic             rd_en,
    input  logic             loopback,
    input  logic             rx_enable,
    input  logic             tx_take,
    output logic [WIDTH-1:0] rd_data,
    output logic [WIDTH-1:0] tx_data,
    output logic             space_avail,
    output logic             data_ready,
    output logic             purge,
    output logic             err
);
    localparam int CW = $clog2(DEPTH+1);

    logic             commit, purge_req, rd_pop_req;
    logic             drop, rd_pop, tx_pop, pop_any;
    logic             full, empty;
    logic [CW-1:0]    count;
    logic [WIDTH-1:0] hold_q, head;

    pfp_phase_decode u_dec (
        .phase      (phase),
        .strobe     (strobe),
        .rd_en      (rd_en),
        .commit     (commit),
        .purge_req  (purge_req),
        .rd_pop_req (rd_pop_req)
    );

    pfp_purge_ctl u_purge (
        .clk       (clk),
        .rst_n     (rst_n),
        .purge_req (purge_req),
        .empty     (empty),
        .rx_enable (rx_enable),
        .purge     (purge),
        .drop      (drop)
    );

    // Combine the pop sources; a read is ignored while purging
    always_comb begin
        rd_pop  = rd_pop_req && !purge;
        tx_pop  = tx_take && !loopback;
        pop_any = drop || rd_pop || tx_pop;
    end

    pfp_ring #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (commit),
        .pop   (pop_any),
        .din   (hold_q),
        .head  (head),
        .count (count),
        .full  (full),
        .empty (empty)
    );

    // Holding register load
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_q <= '0;
        else if (wr_en) hold_q <= wr_data;
    end

    // Read register captures the head on a consuming read
    always_ff @(posedge clk) begin
        if (!rst_n)                 rd_data <= '0;
        else if (rd_pop && !empty)  rd_data <= head;
    end

    // Sticky error on dropped enqueue or pop
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if ((commit && full) || ((rd_pop || tx_pop) && empty))
            err <= 1'b1;
    end

    // Status outputs
    always_comb begin
        tx_data     = head;
        space_avail = !full;
        data_ready  = !empty && !purge;
    end

    // R5
    reread_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_pop_req |=> $stable(rd_data));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R6
    loopback_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loopback && tx_take && !commit && !rd_pop_req && !purge)
        |=> (count == $past(count)));

    // R1
    write_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !strobe && !rd_en && !tx_take && !purge)
        |=> (count == $past(count)));
endmodule

// File: tb/pkt_fifo_port_bench.sv
module pkt_fifo_port_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  phase;
    logic        wr_en, strobe, rd_en, loopback, rx_enable, tx_take;
    logic [15:0] wr_data, rd_data, tx_data;
    logic        space_avail, data_ready, purge, err;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    pkt_fifo_port u_pkt_fifo_port (
        .clk(clk), .rst_n(rst_n), .phase(phase), .wr_en(wr_en), .wr_data(wr_data),
        .strobe(strobe), .rd_en(rd_en), .loopback(loopback), .rx_enable(rx_enable),
        .tx_take(tx_take), .rd_data(rd_data), .tx_data(tx_data),
        .space_avail(space_avail), .data_ready(data_ready), .purge(purge), .err(err)
    );

    // vector: {phase[2], wr, strobe, rd, data[16], exp_ready, exp_rd[16]}
    localparam int NV = 10;
    localparam logic [37:0] VEC [NV] = '{
        {2'd0, 1'b1, 1'b0, 1'b0, 16'hA001, 1'b0, 16'h0000}, // R1 write idle
        {2'd2, 1'b1, 1'b0, 1'b0, 16'hA002, 1'b0, 16'h0000}, // R1 write c2 (overwrites)
        {2'd0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000}, // R2 idle strobe ignored
        {2'd1, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h0000}, // R2 c1 commit A002
        {2'd3, 1'b1, 1'b0, 1'b0, 16'hB003, 1'b1, 16'h0000}, // R1 write c3
        {2'd3, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h0000}, // R2 c3 commit B003
        {2'd3, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h0000}, // R5 c3 reread
        {2'd2, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 16'hA002}, // R4 c2 pop
        {2'd1, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 16'hA002}, // R5 c1 reread
        {2'd2, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0, 16'hB003}  // R4 c2 pop, R9 order
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        phase = 2'd0; wr_en = 1'b0; strobe = 1'b0; rd_en = 1'b0; tx_take = 1'b0;
        wr_data = '0;
    endtask

    // drive at negedge, pass one posedge, release at next negedge
    task automatic op(input logic [1:0] ph, input logic w, input logic s,
                      input logic r, input logic t, input logic [15:0] d);
        phase = ph; wr_en = w; strobe = s; rd_en = r; tx_take = t; wr_data = d;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic push(input logic [15:0] d);
        op(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, d);
        op(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #100000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        idle_inputs();
        loopback = 1'b0; rx_enable = 1'b1;
        @(negedge clk);
        do_reset();

        // R10 reset state
        check("R10 space_avail", {15'd0, space_avail}, 16'd1);
        check("R10 data_ready", {15'd0, data_ready}, 16'd0);
        check("R10 purge", {15'd0, purge}, 16'd0);
        check("R10 err", {15'd0, err}, 16'd0);
        check("R10 rd_data", rd_data, 16'h0);

        // vector walk: R1 R2 R4 R5 R9
        for (int i = 0; i < NV; i++) begin
            op(VEC[i][37:36], VEC[i][35], VEC[i][34], VEC[i][33], 1'b0, VEC[i][32:17]);
            check("R1/R2 data_ready vec", {15'd0, data_ready}, {15'd0, VEC[i][16]});
            check("R4/R5 rd_data vec", rd_data, VEC[i][15:0]);
        end
        check("R8 no err after vectors", {15'd0, err}, 16'd0);

        // R3 purge timing
        push(16'h1111); push(16'h2222); push(16'h3333);
        op(2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
        check("R3 purge set", {15'd0, purge}, 16'd1);
        check("R3 data_ready low in purge", {15'd0, data_ready}, 16'd0);
        @(negedge clk); @(negedge clk);
        check("R3 purge still active", {15'd0, purge}, 16'd1);
        @(negedge clk); @(negedge clk);
        check("R3 purge ends on empty", {15'd0, purge}, 16'd0);
        check("R3 queue emptied", {15'd0, data_ready}, 16'd0);

        // R3 rx_enable low ends purge early
        push(16'h4444); push(16'h5555);
        op(2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
        rx_enable = 1'b0;
        @(negedge clk);
        rx_enable = 1'b1;
        check("R3 purge cleared by rx_enable", {15'd0, purge}, 16'd0);
        check("R3 one word left", {15'd0, data_ready}, 16'd1);
        op(2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
        check("R3 remaining word", rd_data, 16'h5555);

        // R6 loopback suppresses drain
        loopback = 1'b1;
        push(16'h6666); push(16'h7777);
        op(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
        op(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
        op(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
        check("R6 loopback keeps head", tx_data, 16'h6666);
        op(2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
        check("R6 loopback readback", rd_data, 16'h6666);
        loopback = 1'b0;
        check("R6 tx_data head", tx_data, 16'h7777);
        op(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
        check("R6 drain empties", {15'd0, data_ready}, 16'd0);
        check("R8 no err yet", {15'd0, err}, 16'd0);

        // R7 R8 R9 full and wraparound
        for (int k = 0; k < 16; k++) push(16'hC000 + 16'(k));
        check("R7 full space_avail", {15'd0, space_avail}, 16'd0);
        check("R7 full data_ready", {15'd0, data_ready}, 16'd1);
        check("R8 err before overflow", {15'd0, err}, 16'd0);
        push(16'hDEAD);
        check("R8 overflow err", {15'd0, err}, 16'd1);
        for (int k = 0; k < 16; k++) begin
            op(2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
            check("R9 order wrap", rd_data, 16'hC000 + 16'(k));
        end
        check("R7 empty space_avail", {15'd0, space_avail}, 16'd1);
        check("R8 err sticky", {15'd0, err}, 16'd1);

        // R8 empty pop
        do_reset();
        check("R10 err cleared", {15'd0, err}, 16'd0);
        op(2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
        check("R8 empty pop err", {15'd0, err}, 16'd1);
        check("R8 empty pop rd_data", rd_data, 16'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule